// File: doc/BRIEF.md
# Four-Channel DMA Channel Register File

This block is the software-visible register set of a four-channel DMA engine that sits on an 8-bit I/O bus. Each channel keeps a 16-bit start address and a 16-bit transfer count, each as a base copy and a working copy. A 16-bit value is moved through one byte-wide port. A shared byte-pointer toggle decides whether an access reaches the low or the high byte. Each channel also has a mode setting and a mask bit. A channel-wide status byte records which channels have finished.

A small request/acknowledge sequencer sits beside the registers. Whenever an unmasked channel raises its request line, the lowest-numbered such channel is acknowledged for that cycle. Its working address is presented on the address output. On the clock edge the address steps up by one and the count steps down by one. When the count steps below zero, the sequencer signals terminal count. The channel then either reloads its working copies from the base copies or masks itself. A channel set to pass-through mode only echoes its request back as an acknowledge.

Top module: `xfer_chan_regs`

## Requirements
- R1: Offsets 0..7 reach the channel registers. Channel n's address is at offset 2n and its count at offset 2n+1. The first access after the pointer is cleared reaches the low byte and the second reaches the high byte, and every such read or write flips the pointer. A write loads the base and working copies with the same value, and a read returns the working copy.
- R2: A write of any value to offset 0xC clears the byte pointer, so the next channel-register access reaches the low byte.
- R3: A count of N-1 gives N transfers. Terminal count (`tcOut` high together with the acknowledge) comes on the transfer made while the working count is 0x0000. After that transfer the count reads back 0xFFFF.
- R4: A write to offset 0xA picks the channel with bits 1:0. Bit 2 = 1 masks that channel and bit 2 = 0 unmasks it. A masked channel gets no acknowledge.
- R5: A write to offset 0xF loads all four mask bits from data bits 3:0, where bit n belongs to channel n. A write to offset 0xE clears all four mask bits.
- R6: A write to offset 0xD sets all mask bits, clears the byte pointer and clears the status flags.
- R7: A write to offset 0xB sets the mode of the channel chosen by bits 1:0. Bits 3:2 = 01 mean I/O-to-memory, and `xferToMem` is then high during that channel's acknowledge. Bits 3:2 = 10 mean memory-to-I/O, and `xferToMem` is then low. Bit 4 enables autoinitialize. Bits 7:6 = 11 select pass-through.
- R8: Among the unmasked, requesting, non-pass-through channels, the lowest-numbered one is acknowledged. `xferAddr` shows its working address, and each acknowledged cycle advances that address by one.
- R9: At terminal count, a channel with autoinitialize reloads its working address and count from the base copies and stays unmasked. A channel without autoinitialize masks itself.
- R10: A read of offset 0x8 returns the terminal-count flags in bits 3:0, with bit n for channel n and bits 7:4 zero. Those flags clear after the read.
- R11: An unmasked pass-through channel has its acknowledge follow its request. Its address and count do not change, and it never raises terminal count.
- R12: After reset all channels are masked, the pointer is clear, the status is zero and all channel registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | I/O port offset |
| busWrData | input | 8 | Write data |
| busWr | input | 1 | Write strobe, one byte per cycle |
| busRd | input | 1 | Read strobe, one byte per cycle |
| busRdData | output | 8 | Read data, valid in the cycle of `busRd` |
| dreq | input | 4 | Per-channel transfer request |
| dack | output | 4 | Per-channel acknowledge, one transfer per high cycle |
| xferAddr | output | 16 | Working address of the acknowledged channel |
| xferToMem | output | 1 | High when the acknowledged channel moves I/O to memory |
| tcOut | output | 1 | Terminal count for the current transfer |

## Verification
The register path is driven with byte sequences that interleave address writes, count writes and pointer clears. Reading the same port back then shows whether the pointer toggles, whether it resets, and whether the base and working copies agree. The sequencer is driven with single requests, simultaneous requests and masked requests. These patterns separate the priority order, the effect of the single, whole-set and master-clear mask commands, and the two direction codes. Counts of zero and two show exactly where terminal count falls. Running the same channel with autoinitialize on and off tells a reload from a self-mask. A pass-through channel is run and its address read back afterwards, which proves it left its registers untouched.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int CH_BITS = 2;
  localparam int NUM_CH  = 1 << CH_BITS;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int OFF_W   = 4;

  // port offsets whose position software decodes
  localparam logic [OFF_W-1:0] OFF_STATUS = 4'h8;
  localparam logic [OFF_W-1:0] OFF_MASK1  = 4'hA;
  localparam logic [OFF_W-1:0] OFF_MODE   = 4'hB;
  localparam logic [OFF_W-1:0] OFF_PTRCLR = 4'hC;
  localparam logic [OFF_W-1:0] OFF_MCLR   = 4'hD;
  localparam logic [OFF_W-1:0] OFF_UNMASK = 4'hE;
  localparam logic [OFF_W-1:0] OFF_MASKN  = 4'hF;

  typedef struct packed {
    logic [1:0] sel;      // 11 = pass-through
    logic       autoInit;
    logic [1:0] dir;      // 01 = to memory, 10 = from memory
  } modeCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic               ldLo;
    logic               ldHi;
    logic               ldCnt;
    logic [CH_BITS-1:0] ldChan;
    logic [BYTE_W-1:0]  ldByte;
    logic [CH_BITS-1:0] rdChan;
    logic               rdCnt;
    logic               step;
    logic [CH_BITS-1:0] stepChan;
    logic               reload;
  } dpCmd_t;
endpackage

// File: rtl/xfer_dpath.sv
module xfer_dpath
  import xfer_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  dpCmd_t              cmd,
  output logic [WORD_W-1:0]   rdWord,
  output logic [WORD_W-1:0]   stepAddr,
  output logic [NUM_CH-1:0]   cntZero
);
  logic [WORD_W-1:0] curAddrV [NUM_CH];
  logic [WORD_W-1:0] curCntV  [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic [WORD_W-1:0] baseAddr, curAddr, baseCnt, curCnt;
    logic ldHit, stepHit;
    assign ldHit   = (cmd.ldLo | cmd.ldHi) && (cmd.ldChan == CH_BITS'(i));
    assign stepHit = cmd.step && (cmd.stepChan == CH_BITS'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseAddr <= '0;
        curAddr  <= '0;
        baseCnt  <= '0;
        curCnt   <= '0;
      end else begin
        if (stepHit) begin
          if (cmd.reload) begin
            curAddr <= baseAddr;
            curCnt  <= baseCnt;
          end else begin
            curAddr <= curAddr + 1'b1;
            curCnt  <= curCnt - 1'b1;
          end
        end
        // a software write overrides a step on the same cycle
        if (ldHit) begin
          if (cmd.ldCnt) begin
            if (cmd.ldLo) begin
              baseCnt[BYTE_W-1:0] <= cmd.ldByte;
              curCnt <= {baseCnt[WORD_W-1:BYTE_W], cmd.ldByte};
            end else begin
              baseCnt[WORD_W-1:BYTE_W] <= cmd.ldByte;
              curCnt <= {cmd.ldByte, baseCnt[BYTE_W-1:0]};
            end
          end else begin
            if (cmd.ldLo) begin
              baseAddr[BYTE_W-1:0] <= cmd.ldByte;
              curAddr <= {baseAddr[WORD_W-1:BYTE_W], cmd.ldByte};
            end else begin
              baseAddr[WORD_W-1:BYTE_W] <= cmd.ldByte;
              curAddr <= {cmd.ldByte, baseAddr[BYTE_W-1:0]};
            end
          end
        end
      end
    end

    assign curAddrV[i] = curAddr;
    assign curCntV[i]  = curCnt;
    assign cntZero[i]  = (curCnt == '0);
  end

  assign rdWord   = cmd.rdCnt ? curCntV[cmd.rdChan] : curAddrV[cmd.rdChan];
  assign stepAddr = curAddrV[cmd.stepChan];
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [OFF_W-1:0]    busAddr,
  input  logic [BYTE_W-1:0]   busWrData,
  input  logic                busWr,
  input  logic                busRd,
  output logic [BYTE_W-1:0]   busRdData,
  input  logic [NUM_CH-1:0]   dreq,
  output logic [NUM_CH-1:0]   dack,
  output logic                xferToMem,
  output logic                tcOut,
  input  logic [WORD_W-1:0]   rdWord,
  input  logic [NUM_CH-1:0]   cntZero,
  output dpCmd_t              cmd
);
  logic                ptrHi;
  logic [NUM_CH-1:0]   maskBits;
  logic [NUM_CH-1:0]   tcFlags;
  modeCfg_t            modeR [NUM_CH];

  logic                isPort;
  logic [CH_BITS-1:0]  portChan;
  logic [CH_BITS-1:0]  dataChan;
  logic [NUM_CH-1:0]   cascadeV, eligible, grantVec, passVec;
  logic [CH_BITS-1:0]  grantChan;
  logic                grantAny;
  logic                wrMclr, wrPtrClr;

  assign isPort   = (busAddr[OFF_W-1] == 1'b0);
  assign portChan = busAddr[CH_BITS:1];
  assign dataChan = busWrData[CH_BITS-1:0];
  assign wrMclr   = busWr && (busAddr == OFF_MCLR);
  assign wrPtrClr = busWr && (busAddr == OFF_PTRCLR);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cas
    assign cascadeV[i] = (modeR[i].sel == 2'b11);
  end

  assign eligible = dreq & ~maskBits & ~cascadeV;
  assign passVec  = dreq & ~maskBits & cascadeV;

  // fixed priority, channel 0 first
  always_comb begin
    grantChan = '0;
    grantAny  = 1'b0;
    grantVec  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        grantChan = CH_BITS'(i);
        grantAny  = 1'b1;
      end
    end
    if (grantAny) grantVec[grantChan] = 1'b1;
  end

  assign dack      = grantVec | passVec;
  assign tcOut     = grantAny && cntZero[grantChan];
  assign xferToMem = grantAny && (modeR[grantChan].dir == 2'b01);

  always_comb begin
    cmd          = '0;
    cmd.ldLo     = busWr && isPort && !ptrHi;
    cmd.ldHi     = busWr && isPort && ptrHi;
    cmd.ldCnt    = busAddr[0];
    cmd.ldChan   = portChan;
    cmd.ldByte   = busWrData;
    cmd.rdChan   = portChan;
    cmd.rdCnt    = busAddr[0];
    cmd.step     = grantAny;
    cmd.stepChan = grantChan;
    cmd.reload   = tcOut && modeR[grantChan].autoInit;
  end

  always_comb begin
    busRdData = '0;
    if (busRd) begin
      if (isPort)
        busRdData = ptrHi ? rdWord[WORD_W-1:BYTE_W] : rdWord[BYTE_W-1:0];
      else if (busAddr == OFF_STATUS)
        busRdData = BYTE_W'(tcFlags);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrHi    <= 1'b0;
      maskBits <= '1;
      tcFlags  <= '0;
      for (int i = 0; i < NUM_CH; i++) modeR[i] <= '0;
    end else begin
      // byte pointer
      if (wrMclr || wrPtrClr)
        ptrHi <= 1'b0;
      else if ((busWr || busRd) && isPort)
        ptrHi <= !ptrHi;

      // masks: self-mask first, software writes take precedence
      if (tcOut && !modeR[grantChan].autoInit)
        maskBits[grantChan] <= 1'b1;
      if (busWr) begin
        case (busAddr)
          OFF_MASK1:  maskBits[dataChan] <= busWrData[2];
          OFF_UNMASK: maskBits <= '0;
          OFF_MASKN:  maskBits <= busWrData[NUM_CH-1:0];
          OFF_MCLR:   maskBits <= '1;
          default: ;
        endcase
      end

      // status flags
      if (wrMclr)
        tcFlags <= '0;
      else begin
        if (busRd && busAddr == OFF_STATUS)
          tcFlags <= (tcOut ? grantVec : '0);
        else if (tcOut)
          tcFlags <= tcFlags | grantVec;
      end

      // mode
      if (busWr && busAddr == OFF_MODE) begin
        modeR[dataChan].sel      <= busWrData[7:6];
        modeR[dataChan].autoInit <= busWrData[4];
        modeR[dataChan].dir      <= busWrData[3:2];
      end
    end
  end

  logic unusedBit;
  assign unusedBit = busWrData[5];
endmodule

// File: rtl/xfer_chan_regs.sv
module xfer_chan_regs
  import xfer_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [OFF_W-1:0]    busAddr,
  input  logic [BYTE_W-1:0]   busWrData,
  input  logic                busWr,
  input  logic                busRd,
  output logic [BYTE_W-1:0]   busRdData,
  input  logic [NUM_CH-1:0]   dreq,
  output logic [NUM_CH-1:0]   dack,
  output logic [WORD_W-1:0]   xferAddr,
  output logic                xferToMem,
  output logic                tcOut
);
  dpCmd_t              cmd;
  logic [WORD_W-1:0]   rdWord;
  logic [NUM_CH-1:0]   cntZero;

  xfer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData), .dreq(dreq),
    .dack(dack), .xferToMem(xferToMem), .tcOut(tcOut), .rdWord(rdWord),
    .cntZero(cntZero), .cmd(cmd)
  );

  xfer_dpath u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rdWord(rdWord),
    .stepAddr(xferAddr), .cntZero(cntZero)
  );
endmodule

// File: rtl/xfer_chan_regs_chk.sv
module xfer_chan_regs_chk
  import xfer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [OFF_W-1:0]  busAddr,
  input logic [3:0]        wrLow,
  input logic              busWr,
  input logic [NUM_CH-1:0] dreq,
  input logic [NUM_CH-1:0] dack,
  input logic              tcOut
);
  p_ack_needs_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dack & ~dreq) == '0);

  p_tc_with_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    tcOut |-> (dack != '0));

  p_mclr_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFF_MCLR) |=> (dack == '0));

  p_mask_all_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFF_MASKN && wrLow == 4'hF) |=> (dack == '0));

  p_single_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFF_MASK1 && wrLow[2]) |=> !dack[$past(wrLow[1:0])]);
endmodule

bind xfer_chan_regs xfer_chan_regs_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrLow(busWrData[3:0]),
  .busWr(busWr), .dreq(dreq), .dack(dack), .tcOut(tcOut)
);

// File: tb/sim_xfer_chan_regs.sv
module sim_xfer_chan_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [7:0]  busRdData;
  logic [3:0]  dreq = '0, dack;
  logic [15:0] xferAddr;
  logic        xferToMem, tcOut;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xfer_chan_regs u0 (.*);

  typedef struct packed {
    logic       isRd;
    logic [3:0] off;
    logic [7:0] val;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'hC, 8'h00, 4'd2},   // R2 clear pointer
    '{1'b0, 4'h2, 8'h34, 4'd1},   // R1 ch1 address low
    '{1'b0, 4'h2, 8'h12, 4'd1},   // R1 ch1 address high
    '{1'b1, 4'h2, 8'h34, 4'd1},
    '{1'b1, 4'h2, 8'h12, 4'd1},
    '{1'b0, 4'h3, 8'h02, 4'd3},   // R3 count = 3 transfers
    '{1'b0, 4'h3, 8'h00, 4'd3},
    '{1'b1, 4'h3, 8'h02, 4'd3},
    '{1'b1, 4'h3, 8'h00, 4'd3},
    '{1'b0, 4'h2, 8'h78, 4'd2},   // R2 low byte only
    '{1'b0, 4'hC, 8'h55, 4'd2},   // R2 clear mid-pair
    '{1'b1, 4'h2, 8'h78, 4'd2},
    '{1'b1, 4'h2, 8'h12, 4'd2},
    '{1'b0, 4'h2, 8'h34, 4'd1},
    '{1'b0, 4'hC, 8'h00, 4'd2},
    '{1'b1, 4'h8, 8'h00, 4'd10},  // R10 status empty
    '{1'b0, 4'hB, 8'h45, 4'd7}    // R7 ch1 to memory, no autoinit
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] off, input logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = off; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] off, input logic [7:0] exp, input string tag);
    @(negedge clk);
    busRd = 1'b1; busAddr = off;
    #5 chk(tag, busRdData, exp);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic xferOne(input logic [3:0] req, input logic [3:0] expAck,
                         input logic chkAddr, input logic [15:0] expAddr,
                         input logic expTc, input logic expMem, input string tag);
    @(negedge clk);
    dreq = req;
    #5;
    chk(tag, dack, expAck);
    chk(tag, tcOut, expTc);
    if (chkAddr) begin
      chk(tag, xferAddr, expAddr);
      chk(tag, xferToMem, expMem);
    end
    @(negedge clk);
    dreq = '0;
  endtask

  task automatic xferNone(input logic [3:0] req, input string tag);
    @(negedge clk);
    dreq = req;
    #5;
    chk(tag, dack, 4'h0);
    chk(tag, tcOut, 1'b0);
    @(negedge clk);
    dreq = '0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R12 reset state
    xferNone(4'hF, "R12 all masked");
    busRead(4'h8, 8'h00, "R12 status zero");
    busRead(4'h0, 8'h00, "R12 register zero");

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isRd)
        busRead(VECS[i].off, VECS[i].val, $sformatf("R%0d vector %0d", VECS[i].req, i));
      else
        busWrite(VECS[i].off, VECS[i].val);
    end

    // R4 unmask ch1, then R3/R8/R9 three transfers ending in self-mask
    busWrite(4'hA, 8'h01);
    xferOne(4'b0010, 4'b0010, 1, 16'h1234, 0, 1, "R8 step 1");
    xferOne(4'b0010, 4'b0010, 1, 16'h1235, 0, 1, "R8 step 2");
    xferOne(4'b0010, 4'b0010, 1, 16'h1236, 1, 1, "R3 terminal count");
    xferNone(4'b0010, "R9 self-mask");
    busWrite(4'hC, 8'h00);
    busRead(4'h3, 8'hFF, "R3 residue low");
    busRead(4'h3, 8'hFF, "R3 residue high");
    busRead(4'h2, 8'h37, "R8 address advanced");
    busRead(4'h2, 8'h12, "R8 address high");
    busRead(4'h8, 8'h02, "R10 ch1 flag");
    busRead(4'h8, 8'h00, "R10 cleared on read");

    // R9 autoinit on ch2, one transfer per block
    busWrite(4'hB, 8'h56);
    busWrite(4'h4, 8'h10);
    busWrite(4'h4, 8'h00);
    busWrite(4'h5, 8'h00);
    busWrite(4'h5, 8'h00);
    busWrite(4'hA, 8'h02);
    xferOne(4'b0100, 4'b0100, 1, 16'h0010, 1, 1, "R9 autoinit first");
    xferOne(4'b0100, 4'b0100, 1, 16'h0010, 1, 1, "R9 autoinit reloaded");
    busRead(4'h8, 8'h04, "R10 ch2 flag");

    // R7/R8 priority and direction
    busWrite(4'hB, 8'h48);
    busWrite(4'h0, 8'h00);
    busWrite(4'h0, 8'h01);
    busWrite(4'h1, 8'h0F);
    busWrite(4'h1, 8'h00);
    busWrite(4'hB, 8'h47);
    busWrite(4'h6, 8'h00);
    busWrite(4'h6, 8'h03);
    busWrite(4'h7, 8'h05);
    busWrite(4'h7, 8'h00);
    busWrite(4'hE, 8'h00);
    xferOne(4'b1001, 4'b0001, 1, 16'h0100, 0, 0, "R8 ch0 wins, R7 from memory");
    busWrite(4'hA, 8'h04);
    xferOne(4'b1001, 4'b1000, 1, 16'h0300, 0, 1, "R4 ch0 masked, ch3 served");

    // R5 whole-set mask
    busWrite(4'hF, 8'h0F);
    xferNone(4'hF, "R5 all masked");
    busWrite(4'hF, 8'h08);
    xferNone(4'b1000, "R5 ch3 masked");
    xferOne(4'b0001, 4'b0001, 1, 16'h0101, 0, 0, "R5 ch0 open");

    // R11 pass-through on ch3
    busWrite(4'hB, 8'hC3);
    busWrite(4'hF, 8'h07);
    xferOne(4'b1000, 4'b1000, 0, 16'h0, 0, 0, "R11 pass-through ack");
    xferOne(4'b1001, 4'b1000, 0, 16'h0, 0, 0, "R11 with masked ch0");
    busWrite(4'hC, 8'h00);
    busRead(4'h6, 8'h01, "R11 address untouched low");
    busRead(4'h6, 8'h03, "R11 address untouched high");

    // R6 master clear
    busWrite(4'hF, 8'h0B);
    xferOne(4'b0100, 4'b0100, 1, 16'h0010, 1, 1, "R9 ch2 again");
    busWrite(4'h0, 8'hAA);
    busWrite(4'hD, 8'h00);
    xferNone(4'hF, "R6 all masked");
    busRead(4'h8, 8'h00, "R6 status cleared");
    busRead(4'h0, 8'hAA, "R6 pointer cleared");
    busRead(4'h0, 8'h01, "R6 high byte next");

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule